// File: doc/BRIEF.md
# Four-Channel Sample Serializer with Selectable Lane Layout

This block turns parallel 14-bit samples from four converter channels into bit-serial lane streams, one or two lanes per channel, together with a frame marker and a data-clock phase signal. All outputs are single-bit signals that change once per cycle of the bit-rate clock. Six layouts are supported. A channel can use one lane or two lanes, and each word can be 16, 14 or 12 bits long. In two-lane layouts the odd-numbered bits go out on lane A and the even-numbered bits go out on lane B. A 16-bit word is padded with zeros, and a 12-bit word drops the two lowest bits.

A sample-valid strobe copies all four samples into holding registers. At the start of each word, the serializer loads from these holding registers. This means a strobe can arrive at any point in a word without disturbing the bits that are still being shifted out. Two optional transforms act on the data before it is formatted. The first replaces the data with a fixed test word. The second is a randomizer that XORs every bit above the LSB with the LSB. Changes to the lane and width selection are applied only at a frame boundary.

Top module: `lane_formatter`

## Requirements
- R1: While `rst` is high at a clock edge, all lane outputs, `frame` and `dclk` are 0. The holding registers are cleared and the lane/width selection is taken from `two_lane` and `width_sel`. After reset is released, the first output cycle is bit 0 of a new frame.
- R2: Two-lane layout (`two_lane`=1). Lane A sends D13, D11, D9, D7, D5, D3, D1 and lane B sends D12, D10, D8, D6, D4, D2, D0, each MSB first. For 16-bit width (`width_sel`=0) each lane appends one 0 bit. For 14-bit width (`width_sel`=1) each lane sends exactly those 7 bits. For 12-bit width (`width_sel`=2) the last bit of each lane (D1 and D0) is not sent.
- R3: One-lane layout (`two_lane`=0). Lane A sends D13 down to D0. For 16-bit width it then sends two 0 bits, and for 12-bit width it stops after D2. Lane B stays at 0 in every one-lane width.
- R4: Words follow each other with no gap. Each word lasts width/2 bit cycles in two-lane layouts (8, 7 or 6) and width bit cycles in one-lane layouts (16, 14 or 12).
- R5: The frame period equals one word, except in two-lane 14-bit, where it covers two words (14 bit cycles). `frame` is 1 for the first half of each frame period, so a rising edge of `frame` coincides with the first bit of a word.
- R6: `dclk` is 1 on even bit positions of the frame and 0 on odd ones, counting the first bit of the frame as position 0. This gives one data-clock period per two bits.
- R7: When `rand_en` is 1 at the first cycle of a word, that word's bits D13..D1 are each replaced by Dn XOR D0, and D0 is sent unchanged. `frame` and `dclk` are unaffected.
- R8: When `test_en` is 1 at the first cycle of a word, every channel's data for that word is replaced by the parameter `TEST_WORD` (default 14'h2A5C). The randomizer, if enabled, is then applied to this word.
- R9: A change on `two_lane` or `width_sel` takes effect only at the first bit of the next frame. The frame in progress completes in the old layout.
- R10: On a cycle with `smp_valid`=1, all four `smp_data` words are captured. A word loaded at the first cycle of a word uses the most recently captured samples, and a strobe on that same cycle counts only for the following word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Capture strobe for all four samples |
| smp_data | input | 4x14 | Samples, channel n in element n |
| two_lane | input | 1 | 1 = two lanes per channel, 0 = one lane |
| width_sel | input | 2 | 0 = 16-bit, 1 = 14-bit, 2 = 12-bit, 3 treated as 16-bit |
| rand_en | input | 1 | Enables the LSB-XOR randomizer |
| test_en | input | 1 | Replaces the data with the fixed test word |
| lane_a | output | 4 | Lane A bit per channel |
| lane_b | output | 4 | Lane B bit per channel |
| frame | output | 1 | Frame marker, high for the first half of each frame |
| dclk | output | 1 | Data-clock phase, high on even bit positions |

## Verification
The bound checker watches four properties on every cycle. Lane B stays quiet throughout one-lane operation. A rising edge of the frame marker always falls on a high `dclk` phase. `dclk` alternates on every cycle. The active layout only changes right after the last bit of a frame. Whether each bit carries the correct sample bit can only be shown by the bench's behavioural model, which compares every lane bit against it on every clock. This model is exercised across all six layouts, randomizer and test-word runs, layout changes in the middle of a frame, and strobes that arrive at arbitrary offsets within a word.

// File: rtl/lfmt_pkg.sv
package lfmt_pkg;
  typedef enum logic [1:0] {
    WSEL_16 = 2'd0,
    WSEL_14 = 2'd1,
    WSEL_12 = 2'd2
  } wsel_e;

  // bits per lane per word for a given width selection
  function automatic int unsigned word_bits(input wsel_e w, input logic two, input int unsigned dw);
    int unsigned base;
    base = (w == WSEL_14) ? dw : (w == WSEL_12) ? dw - 2 : dw + 2;
    return two ? base / 2 : base;
  endfunction
endpackage

// File: rtl/lfmt_timing.sv
module lfmt_timing
  import lfmt_pkg::*;
#(
  parameter int DW = 14,
  localparam int SW = DW + 2,
  localparam int CW = $clog2(SW + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_two,
  input  logic [1:0] req_w,
  output logic       act_two,
  output wsel_e      act_w,
  output logic       word_start,
  output logic       frame_end,
  output logic       frame_d,
  output logic       dclk_d
);
  logic [CW-1:0] wcnt, wlen, fpos, half;
  logic          wphase, odd, word_end;
  wsel_e         req_norm;

  assign req_norm = (req_w == 2'd3) ? WSEL_16 : wsel_e'(req_w);

  always_comb begin
    wlen       = CW'(word_bits(act_w, act_two, DW));
    odd        = wlen[0];
    fpos       = wphase ? wlen + wcnt : wcnt;
    half       = odd ? wlen : (wlen >> 1);
    word_start = (wcnt == '0);
    word_end   = (wcnt == wlen - 1'b1);
    frame_end  = word_end && (!odd || wphase);
    frame_d    = (fpos < half);
    dclk_d     = ~fpos[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt    <= '0;
      wphase  <= 1'b0;
      act_two <= req_two;
      act_w   <= req_norm;
    end else if (word_end) begin
      wcnt <= '0;
      if (frame_end) begin
        wphase  <= 1'b0;
        act_two <= req_two;
        act_w   <= req_norm;
      end else begin
        wphase <= ~wphase;
      end
    end else begin
      wcnt <= wcnt + 1'b1;
    end
  end
endmodule

// File: rtl/lfmt_chan_fmt.sv
module lfmt_chan_fmt #(
  parameter int DW = 14,
  parameter logic [DW-1:0] TEST_WORD = 14'h2A5C,
  localparam int SW = DW + 2,
  localparam int HW = DW / 2
) (
  input  logic [DW-1:0] hold,
  input  logic          rand_en,
  input  logic          test_en,
  input  logic          two,
  output logic [SW-1:0] word_a,
  output logic [SW-1:0] word_b
);
  logic [DW-1:0] d;

  always_comb begin
    d = test_en ? TEST_WORD : hold;
    if (rand_en) d[DW-1:1] = d[DW-1:1] ^ {(DW-1){d[0]}};
    word_a = '0;
    word_b = '0;
    if (two) begin
      for (int k = 0; k < HW; k++) begin
        word_a[SW-1-k] = d[DW-1-2*k];
        word_b[SW-1-k] = d[DW-2-2*k];
      end
    end else begin
      word_a = {d, 2'b00};
    end
  end
endmodule

// File: rtl/lane_formatter.sv
module lane_formatter
  import lfmt_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 14,
  parameter logic [DW-1:0] TEST_WORD = 14'h2A5C
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_valid,
  input  logic [NCH-1:0][DW-1:0]  smp_data,
  input  logic                    two_lane,
  input  logic [1:0]              width_sel,
  input  logic                    rand_en,
  input  logic                    test_en,
  output logic [NCH-1:0]          lane_a,
  output logic [NCH-1:0]          lane_b,
  output logic                    frame,
  output logic                    dclk
);
  localparam int SW = DW + 2;

  logic  act_two, word_start, frame_end, frame_d, dclk_d;
  wsel_e act_w;

  lfmt_timing #(.DW(DW)) u_timing (
    .clk       (clk),
    .rst       (rst),
    .req_two   (two_lane),
    .req_w     (width_sel),
    .act_two   (act_two),
    .act_w     (act_w),
    .word_start(word_start),
    .frame_end (frame_end),
    .frame_d   (frame_d),
    .dclk_d    (dclk_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frame <= 1'b0;
      dclk  <= 1'b0;
    end else begin
      frame <= frame_d;
      dclk  <= dclk_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] hold_q;
    logic [SW-1:0] word_a, word_b, sh_a, sh_b;

    lfmt_chan_fmt #(.DW(DW), .TEST_WORD(TEST_WORD)) u_fmt (
      .hold   (hold_q),
      .rand_en(rand_en),
      .test_en(test_en),
      .two    (act_two),
      .word_a (word_a),
      .word_b (word_b)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        hold_q    <= '0;
        sh_a      <= '0;
        sh_b      <= '0;
        lane_a[c] <= 1'b0;
        lane_b[c] <= 1'b0;
      end else begin
        if (smp_valid) hold_q <= smp_data[c];
        if (word_start) begin
          lane_a[c] <= word_a[SW-1];
          lane_b[c] <= word_b[SW-1];
          sh_a      <= word_a << 1;
          sh_b      <= word_b << 1;
        end else begin
          lane_a[c] <= sh_a[SW-1];
          lane_b[c] <= sh_b[SW-1];
          sh_a      <= sh_a << 1;
          sh_b      <= sh_b << 1;
        end
      end
    end
  end
endmodule

// File: rtl/lane_formatter_chk.sv
module lane_formatter_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] lane_b,
  input logic           frame,
  input logic           dclk,
  input logic           act_two,
  input logic [1:0]     act_w,
  input logic           frame_end
);
  // R3: one-lane layout keeps lane B at zero
  p_laneb_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(act_two) |-> (lane_b == '0));

  // R5: a new frame starts on an even bit position
  p_frame_phase_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(frame) |-> dclk);

  // R6: data-clock phase alternates every bit cycle
  p_dclk_toggle_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (dclk != $past(dclk)));

  // R9: layout changes only after the last bit of a frame
  p_mode_at_frame_r9: assert property (@(posedge clk) disable iff (rst)
    (act_two != $past(act_two) || act_w != $past(act_w)) |-> $past(frame_end));
endmodule

bind lane_formatter lane_formatter_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .lane_b   (lane_b),
  .frame    (frame),
  .dclk     (dclk),
  .act_two  (act_two),
  .act_w    (act_w),
  .frame_end(frame_end)
);

// File: tb/lane_formatter_test.sv
module lane_formatter_test;
  localparam logic [13:0] TW = 14'h2A5C;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              smp_valid = 1'b0;
  logic [3:0][13:0]  smp_data = '0;
  logic              two_lane = 1'b1;
  logic [1:0]        width_sel = 2'd0;
  logic              rand_en = 1'b0;
  logic              test_en = 1'b0;
  logic [3:0]        lane_a, lane_b;
  logic              frame, dclk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit started = 0, done = 0;

  always #10 clk = ~clk;

  lane_formatter #(.NCH(4), .DW(14), .TEST_WORD(TW)) uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .two_lane(two_lane), .width_sel(width_sel), .rand_en(rand_en),
    .test_en(test_en), .lane_a(lane_a), .lane_b(lane_b),
    .frame(frame), .dclk(dclk)
  );

  // behavioural reference model
  int          fpos, m_w;
  bit          m_two, fresh;
  logic [13:0] hold_m [4];
  logic [13:0] wd [4];
  logic [3:0]  ea, eb;
  logic        ef, ed;
  string       wtag, ltag;

  function automatic int wbits(input bit two, input int w);
    int base;
    base = (w == 1) ? 14 : (w == 2) ? 12 : 16;
    return two ? base / 2 : base;
  endfunction

  function automatic logic bit_a(input logic [13:0] d, input bit two, input int k);
    if (two) return (k < 7) ? d[13-2*k] : 1'b0;
    return (k < 14) ? d[13-k] : 1'b0;
  endfunction

  function automatic logic bit_b(input logic [13:0] d, input bit two, input int k);
    if (two) return (k < 7) ? d[12-2*k] : 1'b0;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      for (int c = 0; c < 4; c++) begin hold_m[c] = '0; wd[c] = '0; end
      fpos = 0; m_two = two_lane; m_w = (width_sel == 3) ? 0 : int'(width_sel);
      fresh = 0; ea = '0; eb = '0; ef = 0; ed = 0; ltag = "R1";
    end else begin
      int wl, fl, idx;
      wl  = wbits(m_two, m_w);
      fl  = (wl % 2 == 1) ? 2 * wl : wl;
      idx = fpos % wl;
      if (idx == 0) begin
        for (int c = 0; c < 4; c++) begin
          logic [13:0] d;
          d = test_en ? TW : hold_m[c];
          if (rand_en) for (int b = 1; b < 14; b++) d[b] = d[b] ^ d[0];
          wd[c] = d;
        end
        if (test_en)      wtag = "R8";
        else if (rand_en) wtag = "R7";
        else if (fresh)   wtag = "R9";
        else              wtag = m_two ? "R2 R4 R10" : "R3 R4 R10";
      end
      for (int c = 0; c < 4; c++) begin
        ea[c] = bit_a(wd[c], m_two, idx);
        eb[c] = bit_b(wd[c], m_two, idx);
      end
      ltag = wtag;
      ef = (fpos < fl / 2);
      ed = (fpos % 2 == 0);
      fpos++;
      if (fpos == fl) begin
        int nw;
        nw = (width_sel == 3) ? 0 : int'(width_sel);
        fresh = (nw != m_w) || (two_lane != m_two);
        fpos = 0; m_two = two_lane; m_w = nw;
      end
      if (smp_valid) for (int c = 0; c < 4; c++) hold_m[c] = smp_data[c];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      cyc++;
      chk({lane_a, lane_b} === {ea, eb}, ltag, {8'b0, lane_a, lane_b}, {8'b0, ea, eb});
      chk(frame === ef, rst ? "R1" : "R5", {15'b0, frame}, {15'b0, ef});
      chk(dclk === ed, rst ? "R1" : "R6", {15'b0, dclk}, {15'b0, ed});
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic run_phase(input bit two, input int w, input bit rnd, input bit tst, input int n);
    @(negedge clk);
    two_lane = two; width_sel = 2'(w); rand_en = rnd; test_en = tst;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = ($urandom_range(0, 5) == 0);
      for (int c = 0; c < 4; c++) smp_data[c] = 14'($urandom);
    end
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    run_phase(1, 0, 0, 0, 300);  // two-lane 16
    run_phase(1, 1, 0, 0, 300);  // two-lane 14
    run_phase(1, 2, 0, 0, 300);  // two-lane 12
    run_phase(0, 0, 0, 0, 300);  // one-lane 16
    run_phase(0, 1, 0, 0, 300);  // one-lane 14
    run_phase(0, 2, 0, 0, 300);  // one-lane 12
    run_phase(1, 0, 1, 0, 200);  // randomizer
    run_phase(0, 1, 1, 0, 200);
    run_phase(1, 1, 0, 1, 200);  // test word
    run_phase(0, 0, 1, 1, 200);  // test word with randomizer
    for (int r = 0; r < 20; r++)  // layout changes mid-frame
      run_phase(bit'($urandom_range(0, 1)), $urandom_range(0, 2), 0, 0, $urandom_range(3, 40));
    @(negedge clk); rst = 1'b1;   // second reset
    repeat (2) @(negedge clk); rst = 1'b0;
    run_phase(1, 2, 0, 0, 100);
    finish_run();
  end
endmodule